// File: doc/BRIEF.md
# CAN Receive Bit Sampler

This block watches the receive wire of a CAN bus, clocked by a system clock that runs much faster than the bit rate. While the bus is idle it waits for the wire to go dominant (logic 0). It takes the clock edge on which it first sees that level as the time reference for the frame. From then on it issues one strobe per nominal bit, including stuff bits, at a fixed point inside each bit period. A downstream frame decoder consumes the strobed bit values and tells the sampler when the frame is over.

Every sample instant is derived from that single start-of-frame reference. Bit n is taken `n * bit_cycles + offset` cycles after the reference. The offset is the bit width scaled by a sample-point percentage, with the fraction dropped. No edge after the start-of-frame edge adjusts the timing. The bit width and the percentage are captured when a frame starts and stay fixed for the rest of that frame. The decoder can end the frame normally with `frame_done`, or cancel it with `abort`. Either returns the sampler to the hunt for the next dominant level.

Top module: `can_bit_sampler`

## Requirements
- R1: While reset is asserted and immediately after it is released, `frame_active` and `bit_valid` are 0.
- R2: `rx` passes through a two-flop synchroniser before it is used. If `rx` falls just after clock edge k while the sampler is idle, `frame_active` is 0 after edge k+2 and 1 after edge k+3.
- R3: For a frame whose `rx` falling edge follows clock edge k, the strobe for raw bit n (n = 0 is the start-of-frame bit) makes `bit_valid` high for exactly one cycle, after edge k + 4 + offset + n * bit_cycles. This holds for every raw bit, whatever the bit values are.
- R4: offset = floor(bit_cycles * sp_pct / 100). The percentage is limited to 100.
- R5: With `rx` held constant over each bit period, `bit_value` at a strobe equals the level of `rx` during bit n.
- R6: `bit_cycles` and `sp_pct` are captured at start of frame. Changing them during a frame does not move that frame's strobes.
- R7: A one-cycle pulse on `frame_done` clears `frame_active` at the next clock edge. The sampler then waits for the next dominant level and re-arms on it.
- R8: A pulse on `abort` clears `frame_active` at the next clock edge. No strobe follows it while `rx` stays recessive.
- R9: No strobe occurs while the sampler is idle, for example with `rx` held recessive after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx | input | 1 | CAN receive wire, asynchronous; 0 is dominant |
| bit_cycles | input | W_W (16) | System clocks per nominal bit |
| sp_pct | input | P_W (7) | Sample point as a percentage of the bit period |
| frame_done | input | 1 | Pulse from the decoder: frame finished, return to idle |
| abort | input | 1 | Pulse from the decoder: cancel the frame, return to idle |
| bit_valid | output | 1 | One-cycle strobe: a raw bit was sampled |
| bit_value | output | 1 | Level sampled at the latest strobe |
| frame_active | output | 1 | High from start of frame until done or abort |

## Verification
Frames are run with several pairs of bit width and sample point. The pairs include a zero offset, offsets whose exact value has a fraction that must be truncated, and widths from 8 to 50 cycles. A wrong rounding or a wrong cycle count therefore shows up as a strobe in the wrong cycle. The payload patterns include a long run of dominant bits, a long run of recessive bits and alternating bits. These show that strobes keep coming once per raw bit whatever the content, and that each strobe lands inside its own bit. Directed runs change the configuration in the middle of a frame and abort in the middle of a frame. They also hold the line recessive while the sampler is idle, to separate captured settings from live settings and to separate a true return to idle from a stalled counter.

// File: rtl/can_smp_pkg.sv
package can_smp_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FRAME = 1'b1
  } smp_state_e;

  // Sample offset in whole cycles: width scaled by a percentage, fraction dropped.
  function automatic logic [31:0] sp_offset(input logic [31:0] width,
                                            input logic [31:0] pct);
    logic [31:0] p;
    p = (pct > 32'd100) ? 32'd100 : pct;
    return (width * p) / 32'd100;
  endfunction

endpackage

// File: rtl/can_smp_sync.sv
module can_smp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  // Reset to recessive so the line reads idle until real samples arrive.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/can_smp_ctrl.sv
module can_smp_ctrl
  import can_smp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rx_s,
  input  logic frame_done,
  input  logic abort,
  output logic sof,
  output logic active
);
  smp_state_e state_q;

  assign sof    = (state_q == ST_IDLE) && !rx_s && !abort;
  assign active = (state_q == ST_FRAME);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  state_q <= ST_IDLE;
    else if (abort || frame_done) state_q <= ST_IDLE;
    else if (sof)                state_q <= ST_FRAME;
  end

  assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !active);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !active);

  assert_start_on_dominant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(!rx_s));
endmodule

// File: rtl/can_smp_timer.sv
module can_smp_timer
  import can_smp_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int W_W   = 16,
  parameter int P_W   = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sof,
  input  logic           active,
  input  logic [W_W-1:0] bit_cycles,
  input  logic [P_W-1:0] sp_pct,
  output logic           hit
);
  logic [CNT_W-1:0] since_q;   // cycles elapsed since the start-of-frame edge
  logic [CNT_W-1:0] target_q;  // elapsed count of the next sample instant
  logic [CNT_W-1:0] width_q;   // bit width captured at start of frame

  assign hit = active && (since_q == target_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q  <= '0;
      target_q <= '0;
      width_q  <= '0;
    end else if (sof) begin
      since_q  <= '0;
      width_q  <= CNT_W'(bit_cycles);
      target_q <= CNT_W'(sp_offset(32'(bit_cycles), 32'(sp_pct)));
    end else if (active) begin
      since_q <= since_q + 1'b1;
      if (hit) target_q <= target_q + width_q;
    end
  end

  assert_one_cycle_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && width_q > 1) |=> !hit);
endmodule

// File: rtl/can_bit_sampler.sv
module can_bit_sampler #(
  parameter int CNT_W = 24,
  parameter int W_W   = 16,
  parameter int P_W   = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rx,
  input  logic [W_W-1:0] bit_cycles,
  input  logic [P_W-1:0] sp_pct,
  input  logic           frame_done,
  input  logic           abort,
  output logic           bit_valid,
  output logic           bit_value,
  output logic           frame_active
);
  logic rx_s;
  logic sof;
  logic active;
  logic hit;

  can_smp_sync #(.STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rx),
    .dout (rx_s)
  );

  can_smp_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_s      (rx_s),
    .frame_done(frame_done),
    .abort     (abort),
    .sof       (sof),
    .active    (active)
  );

  can_smp_timer #(.CNT_W(CNT_W), .W_W(W_W), .P_W(P_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .sof       (sof),
    .active    (active),
    .bit_cycles(bit_cycles),
    .sp_pct    (sp_pct),
    .hit       (hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_valid <= 1'b0;
      bit_value <= 1'b1;
    end else begin
      bit_valid <= hit;
      if (hit) bit_value <= rx_s;
    end
  end

  assign frame_active = active;

  assert_strobe_only_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> $past(frame_active));
endmodule

// File: tb/can_bit_sampler_test.sv
`timescale 1ns/1ps
module can_bit_sampler_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx = 1'b1;
  logic [15:0] bit_cycles = 16'd50;
  logic [6:0]  sp_pct = 7'd70;
  logic        frame_done = 1'b0;
  logic        abort = 1'b0;
  logic        bit_valid, bit_value, frame_active;

  can_bit_sampler uut (
    .clk(clk), .rst_n(rst_n), .rx(rx), .bit_cycles(bit_cycles), .sp_pct(sp_pct),
    .frame_done(frame_done), .abort(abort), .bit_valid(bit_valid),
    .bit_value(bit_value), .frame_active(frame_active)
  );

  always #10 clk = ~clk;  // 50 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  logic mon_en = 1'b0;
  string mon_tag = "R9";
  int exp_base = 0, exp_off = 0, exp_w = 1, n_seen = 0;
  logic [7:0] exp_pat = 8'h00;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Strobe monitor: time (R3, R4) and value (R5) of every strobe.
  always @(negedge clk) begin
    if (bit_valid) begin
      if (mon_en) begin
        chk("R3/R4 strobe cycle", cyc, exp_base + 4 + exp_off + n_seen * exp_w);
        chk("R5 bit value", int'(bit_value),
            (n_seen == 0) ? 0 : (n_seen <= 8) ? int'(exp_pat[8 - n_seen]) : 1);
        n_seen++;
      end else begin
        chk({mon_tag, " unexpected strobe"}, 1, 0);
      end
    end
  end

  // Vector table: bit width, sample point percentage, 8 payload bits.
  localparam int NV = 5;
  localparam int VW [NV] = '{50, 20, 12, 8, 33};
  localparam int VP [NV] = '{70, 50, 0, 87, 33};
  localparam logic [7:0] VD [NV] = '{8'hA5, 8'h00, 8'hFF, 8'h3C, 8'h81};

  task automatic run_frame(input int w, input int p, input logic [7:0] pat, input int chg_w);
    @(negedge clk);
    bit_cycles = 16'(w); sp_pct = 7'(p);
    exp_w = w; exp_off = (w * p) / 100; exp_pat = pat;
    n_seen = 0; exp_base = cyc; mon_en = 1'b1; rx = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R2 inactive after k+2", int'(frame_active), 0);
    @(negedge clk);
    chk("R2 active after k+3", int'(frame_active), 1);
    if (chg_w != 0) begin  // R6: new settings must not affect this frame
      bit_cycles = 16'(chg_w); sp_pct = 7'd5;
    end
    repeat (w - 3) @(negedge clk);
    for (int i = 1; i <= 8; i++) begin
      rx = pat[8 - i];
      repeat (w) @(negedge clk);
    end
    rx = 1'b1;
    while (n_seen < 10) @(posedge clk);
    @(negedge clk);
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
    chk("R7 idle after frame_done", int'(frame_active), 0);
    chk("R3 strobe count per frame", n_seen, 10);
    mon_en = 1'b0; mon_tag = "R7";
    repeat (20) @(negedge clk);
  endtask

  initial begin
    int s;
    repeat (3) @(negedge clk);
    chk("R1 frame_active in reset", int'(frame_active), 0);
    chk("R1 bit_valid in reset", int'(bit_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 frame_active after reset", int'(frame_active), 0);
    chk("R1 bit_valid after reset", int'(bit_valid), 0);

    // R9: recessive line while idle gives no strobe
    mon_tag = "R9";
    s = 0;
    repeat (100) begin @(negedge clk); if (bit_valid) s++; end
    chk("R9 strobes while idle", s, 0);
    chk("R9 still idle", int'(frame_active), 0);

    for (int i = 0; i < NV; i++) run_frame(VW[i], VP[i], VD[i], 0);

    // R6: mid-frame change of width and sample point
    run_frame(20, 50, 8'h5A, 30);

    // R8: abort in the middle of a frame
    @(negedge clk);
    bit_cycles = 16'd20; sp_pct = 7'd50;
    exp_w = 20; exp_off = 10; exp_pat = 8'hFF;
    n_seen = 0; exp_base = cyc; mon_en = 1'b1; rx = 1'b0;
    repeat (20) @(negedge clk);
    rx = 1'b1;
    while (n_seen < 3) @(posedge clk);
    @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk("R8 idle after abort", int'(frame_active), 0);
    mon_en = 1'b0; mon_tag = "R8";
    s = 0;
    repeat (200) begin @(negedge clk); if (bit_valid) s++; end
    chk("R8 strobes after abort", s, 0);

    // R7: re-arm after abort and done with a fresh frame
    run_frame(16, 75, 8'hC3, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule